// File: doc/BRIEF.md
# Block Survivor Trace-Back for a Four-State Trellis

This block recovers the decoded bit sequence of a four-state trellis that is decoded in fixed, independent blocks of trellis steps instead of one endless recursive chain. An add-compare-select stage upstream produces one decision vector per trellis step. Bit i of that vector is the survivor decision of state i. The block stores one full block of these vectors in arrival order. Once the last vector of the block arrives, it walks the trellis backward from a chosen end state, one step per clock.

At every backward step, a four-way selection picks the decision bit that belongs to the current state. That bit, together with the current state, gives the predecessor state. The most significant bit of the current state is the decoded bit for that step. The bits are produced newest-first and are collected into a word ordered oldest-first. A one-cycle strobe announces the finished word, and the next block may begin at once.

Top module: `survivor_traceback`

## Requirements
- R1: After reset, `done` is low and `bitsOut` is all zeros.
- R2: A decision vector is accepted on every clock edge where `decValid` is high while the block is filling. Idle cycles between vectors do not count. The k-th accepted vector (k = 0 first) is stored as step k. The vector of step BLOCK_LEN-1 ends the fill and starts the trace-back.
- R3: The end state of the walk is the value on `startState` in the cycle that the last vector of the block is accepted. Values of `startState` in any other cycle have no effect.
- R4: At the backward step for step k with current state s (2 bits), the decoded bit of step k is s[1]. With d = bit s of the vector of step k, the next state is (s>>1) + 2·d.
- R5: In the output word, bit k of `bitsOut` is the decoded bit of step k. Bit 0 is the oldest step and bit BLOCK_LEN-1 is the newest.
- R6: `done` is high for exactly one cycle. It rises BLOCK_LEN clock edges after the edge that accepted the last vector. `bitsOut` changes only together with `done` and holds its value until the next `done`.
- R7: Decision vectors presented while the trace-back runs are ignored. They change neither the result nor the fill count of the next block.
- R8: A new block may start in the cycle where `done` is high. A vector presented then is accepted as step 0 of the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| decValid | input | 1 | Decision vector valid |
| decVec | input | NUM_STATES (4) | Survivor decision per state, bit i for state i |
| startState | input | STATE_W (2) | End state of the backward walk, normally 0 |
| bitsOut | output | BLOCK_LEN (32) | Decoded word, bit 0 oldest |
| done | output | 1 | One-cycle strobe: bitsOut holds a new word |

## Verification
The bench goes after the following corner cases:
- A block whose only nonzero decision sits in the newest step. This catches a predecessor rule that shifts the wrong way or takes the decision from the wrong state: such a design produces a word other than 0x40000000.
- An all-zero block walked from state 2. This catches reversed output ordering, which would put the single set bit at bit 0 instead of bit 31.
- Random decisions with idle gaps during fill, with vectors injected during the trace, and with `startState` toggled in every cycle but the sampling one. These catch a counter that advances on idle cycles, a memory that is overwritten mid-trace, and an end state latched at the wrong time; each of these gives a wrong word or a wrong latency.
- A block fed back-to-back into the `done` cycle. This exposes a design that drops that first vector: its next word arrives one vector late, so its latency is wrong.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic wrEn;      // store decision vector at addr
    logic loadStart; // take startState as the walk's initial state
    logic step;      // one backward step at addr
    logic publish;   // final step: move the word to the output
  } tbuCtl_t;
endpackage

// File: rtl/tbu_ctl.sv
module tbu_ctl
  import tbu_pkg::*;
#(
  parameter int BLOCK_LEN = 32,
  parameter int ADDR_W    = $clog2(BLOCK_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  output tbuCtl_t           ctl,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BLOCK_LEN - 1);

  typedef enum logic {FILL, TRACE} phase_t;
  phase_t            phase;
  logic [ADDR_W-1:0] count;

  always_comb begin
    ctl  = '0;
    addr = count;
    if (phase == FILL) begin
      ctl.wrEn      = decValid;
      ctl.loadStart = decValid && (count == LAST);
    end else begin
      ctl.step    = 1'b1;
      ctl.publish = (count == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= FILL;
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= ctl.publish;
      if (phase == FILL) begin
        if (ctl.loadStart) phase <= TRACE;
        else if (decValid) count <= count + 1'b1;
      end else begin
        if (ctl.publish) begin
          phase <= FILL;
          count <= '0;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end

  // Checker: steps taken since the walk began
  logic [ADDR_W:0] stepCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepCnt <= '0;
    else if (ctl.loadStart) stepCnt <= '0;
    else if (ctl.step) stepCnt <= stepCnt + 1'b1;
  end

  AST_TRACE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.publish |-> stepCnt == (ADDR_W+1)'(BLOCK_LEN - 1)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_START_AFTER_FILL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadStart |=> ctl.step); // R2
endmodule

// File: rtl/tbu_dp.sv
module tbu_dp
  import tbu_pkg::*;
#(
  parameter int BLOCK_LEN  = 32,
  parameter int NUM_STATES = 4,
  parameter int ADDR_W     = $clog2(BLOCK_LEN),
  parameter int STATE_W    = $clog2(NUM_STATES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tbuCtl_t               ctl,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_STATES-1:0] decVec,
  input  logic [STATE_W-1:0]    startState,
  output logic [BLOCK_LEN-1:0]  bitsOut
);
  logic [NUM_STATES-1:0] decMem [BLOCK_LEN];
  logic [STATE_W-1:0]    curState;
  logic [BLOCK_LEN-1:0]  shadow;
  logic [BLOCK_LEN-1:0]  wordNext;
  logic                  selDec;
  logic [STATE_W-1:0]    prevState;

  always_ff @(posedge clk) begin
    if (ctl.wrEn) decMem[addr] <= decVec;
  end

  // Four-way pick of the current state's survivor decision
  always_comb begin
    selDec         = decMem[addr][curState];
    prevState      = {selDec, curState[STATE_W-1:1]};
    wordNext       = shadow;
    wordNext[addr] = curState[STATE_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= '0;
      shadow   <= '0;
      bitsOut  <= '0;
    end else begin
      if (ctl.loadStart) curState <= startState;
      else if (ctl.step) curState <= prevState;
      if (ctl.step) shadow <= wordNext;
      if (ctl.publish) bitsOut <= wordNext;
    end
  end

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadStart |=> curState == $past(startState)); // R3
  AST_PRED_RULE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.loadStart) |=>
      curState[STATE_W-2:0] == $past(curState[STATE_W-1:1])); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.publish |=> $stable(bitsOut)); // R6
  AST_NO_WRITE_IN_TRACE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> !ctl.wrEn); // R7
endmodule

// File: rtl/survivor_traceback.sv
module survivor_traceback
  import tbu_pkg::*;
#(
  parameter int BLOCK_LEN  = 32,
  parameter int NUM_STATES = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             decValid,
  input  logic [NUM_STATES-1:0]            decVec,
  input  logic [$clog2(NUM_STATES)-1:0]    startState,
  output logic [BLOCK_LEN-1:0]             bitsOut,
  output logic                             done
);
  localparam int ADDR_W  = $clog2(BLOCK_LEN);
  localparam int STATE_W = $clog2(NUM_STATES);

  tbuCtl_t           ctl;
  logic [ADDR_W-1:0] addr;

  tbu_ctl #(.BLOCK_LEN(BLOCK_LEN), .ADDR_W(ADDR_W)) uCtl (
    .clk(clk), .rstN(rstN), .decValid(decValid),
    .ctl(ctl), .addr(addr), .done(done)
  );

  tbu_dp #(.BLOCK_LEN(BLOCK_LEN), .NUM_STATES(NUM_STATES),
           .ADDR_W(ADDR_W), .STATE_W(STATE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addr(addr),
    .decVec(decVec), .startState(startState), .bitsOut(bitsOut)
  );
endmodule

// File: tb/sim_survivor_traceback.sv
module sim_survivor_traceback;
  localparam int BL = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN;
  logic          decValid;
  logic [3:0]    decVec;
  logic [1:0]    startState;
  logic [BL-1:0] bitsOut;
  logic          done;

  int checks = 0;
  int errors = 0;
  logic [3:0]  blk [BL];
  logic [31:0] lfsr = 32'h1ACE5EED;

  survivor_traceback u0 (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decVec(decVec),
    .startState(startState), .bitsOut(bitsOut), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  // Reference walk built from R4/R5
  function automatic logic [BL-1:0] model(input logic [1:0] st);
    logic [BL-1:0] w;
    logic [1:0]    s;
    s = st;
    w = '0;
    for (int k = BL - 1; k >= 0; k--) begin
      w[k] = s[1];
      s    = {blk[k][s], s[1]};
    end
    return w;
  endfunction

  task automatic fillConst(input logic [3:0] v);
    for (int i = 0; i < BL; i++) blk[i] = v;
  endtask

  task automatic fillRand();
    for (int i = 0; i < BL; i++) blk[i] = nextRand() & 4'hF;
  endtask

  // Feed blk; gaps inserts idle cycles; startState valid only on the last vector
  task automatic feed(input logic [1:0] st, input bit gaps);
    for (int i = 0; i < BL; i++) begin
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk);
        decValid   = 1'b0;
        decVec     = 4'hF;
        startState = ~st;
      end
      @(negedge clk);
      decValid   = 1'b1;
      decVec     = blk[i];
      startState = (i == BL - 1) ? st : ~st;
    end
  endtask

  task automatic waitDone(input bit junk, input logic [BL-1:0] exp,
                          input string tag);
    int cyc;
    cyc = 0;
    while (cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (done) break;
      decValid   = junk;
      decVec     = nextRand() & 4'hF;
      startState = startState ^ 2'b11;
    end
    decValid = 1'b0;
    chk(cyc == BL + 1, {tag, " R6 latency"}, cyc, BL + 1);
    chk(bitsOut == exp, {tag, " word"}, bitsOut, exp);
    @(negedge clk);
    chk(!done, "R6 single-cycle done", done, 0);
    chk(bitsOut == exp, "R6 word held", bitsOut, exp);
  endtask

  task automatic testReset();
    rstN = 1'b0; decValid = 1'b0; decVec = '0; startState = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(bitsOut == '0, "R1 word after reset", bitsOut, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testConst();
    fillConst(4'h0); feed(2'd0, 0);
    waitDone(0, 32'h0, "R4 zero decisions from state 0");
    fillConst(4'hF); feed(2'd3, 0);
    waitDone(0, 32'hFFFF_FFFF, "R4 one decisions from state 3");
    fillConst(4'h0); feed(2'd2, 0);
    waitDone(0, 32'h8000_0000, "R5 oldest-first order");
  endtask

  task automatic testHand();
    fillConst(4'h0); blk[BL-1] = 4'b0001; feed(2'd0, 0);
    waitDone(0, 32'h4000_0000, "R4 predecessor rule");
  endtask

  task automatic testGaps();
    logic [BL-1:0] e;
    fillRand(); e = model(2'd1); feed(2'd1, 1);
    waitDone(0, e, "R2 R3 random with idle gaps");
  endtask

  task automatic testJunk();
    logic [BL-1:0] e;
    fillRand(); e = model(2'd3); feed(2'd3, 0);
    waitDone(1, e, "R7 vectors during trace");
    fillRand(); e = model(2'd0); feed(2'd0, 0);
    waitDone(0, e, "R7 next block unaffected");
  endtask

  task automatic testBackToBack();
    logic [BL-1:0] eA, eB;
    int cyc;
    fillRand(); eA = model(2'd1); feed(2'd1, 0);
    cyc = 0;
    while (cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (done) break;
      decValid = 1'b0;
    end
    chk(bitsOut == eA, "R8 first word", bitsOut, eA);
    fillRand(); eB = model(2'd2);
    decValid = 1'b1; decVec = blk[0]; startState = 2'd1;
    for (int i = 1; i < BL; i++) begin
      @(negedge clk);
      if (i == 1) chk(!done, "R6 done single cycle (back-to-back)", done, 0);
      decVec     = blk[i];
      startState = (i == BL - 1) ? 2'd2 : 2'd1;
    end
    waitDone(0, eB, "R8 block started in done cycle");
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    testReset();
    testConst();
    testHand();
    testGaps();
    testJunk();
    testBackToBack();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    report();
  end
endmodule